// File: doc/BRIEF.md
# Service Request Status Byte Logic

This block is the status-reporting core of an instrument attached to a controller bus. Three summary inputs feed an 8-bit status byte. Two event-summary bits come from event logic outside the block. The third input is a message-available flag, which is high while the output queue holds data. The host writes an 8-bit request-enable mask, and that mask selects which status bits may raise a service request. From the masked bits the block computes a master summary bit and drives a service request line. It also supplies the byte returned to the controller during a serial poll.

A request is raised only when an enabled status bit goes from 0 to 1. A bit that stays high does not raise a second request. A small two-state controller holds the request. State `REQ_IDLE` means no request is outstanding. The transition `RAISE` (an enabled rising edge) moves it to `REQ_PENDING`. The transition `POLL_CLEAR` (a poll-byte read with no new rising edge in the same cycle) returns it to `REQ_IDLE`. A rising edge in `REQ_PENDING` keeps the controller in `REQ_PENDING` (transition `HOLD`), even when a poll read happens in the same cycle.

Top module: `srq_status_core`

## Requirements
- R1: After reset the enable register reads 0x00 and `srq_o` is low while no input changes.
- R2: `status_byte` carries `evt_hi_i` in bit 5, `queue_nonempty_i` in bit 4 and `evt_lo_i` in bit 0. Bits 7, 3, 2 and 1 always read 0.
- R3: A write to the enable register is visible on `enable_q` and takes effect in the cycle after the write strobe. Only bits 5, 4 and 0 are stored; every other bit, bit 6 included, reads 0 whatever was written.
- R4: Bit 6 of `status_byte` equals the OR of status bits 5, 4 and 0, each ANDed with the matching enable bit, in the same cycle.
- R5: When an enabled source bit is 1 in a cycle and was 0 in the previous cycle, `srq_o` is high in that same cycle.
- R6: A source bit that stays high, or rises while its enable bit is 0, does not raise `srq_o`.
- R7: Once raised, `srq_o` stays high until a cycle with `poll_rd_i` high and is low in the following cycle, provided no new enabled rising edge occurs. `poll_byte` equals `status_byte` with bit 6 replaced by `srq_o`.
- R8: An enabled rising edge in the same cycle as a poll read leaves `srq_o` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_hi_i | input | 1 | Event summary feeding status bit 5 |
| queue_nonempty_i | input | 1 | Output queue holds data; status bit 4 |
| evt_lo_i | input | 1 | Second event summary; status bit 0 |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| enable_q | output | 8 | Enable register contents |
| status_byte | output | 8 | Live status byte with master summary in bit 6 |
| poll_rd_i | input | 1 | Serial poll byte read strobe |
| poll_byte | output | 8 | Serial poll response byte |
| srq_o | output | 1 | Service request |

## Verification
The hardest case to reach is a rising edge on an enabled bit in the same cycle that the controller reads the poll byte. A second hard case is a source bit that rises in the same cycle its enable bit is written. By the rules above, neither of these may clear or create a request out of turn. The stimulus sequence first builds an outstanding request. It then drops a source, re-raises it exactly on the poll cycle, and later pairs a rise with an enable write. A behavioural model compares every output on every clock.

// File: rtl/srq_pkg.sv
package srq_pkg;
    localparam int SB_W     = 8;
    localparam int BIT_MSS  = 6;
    localparam int BIT_HI   = 5;
    localparam int BIT_MAV  = 4;
    localparam int BIT_LO   = 0;
    localparam logic [SB_W-1:0] SRC_MASK =
        SB_W'((1 << BIT_HI) | (1 << BIT_MAV) | (1 << BIT_LO));

    typedef enum logic {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_t;
endpackage

// File: rtl/srq_status_assemble.sv
module srq_status_assemble
    import srq_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         hi_i,
    input  logic         mav_i,
    input  logic         lo_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] src_o,
    output logic         mss_o
);
    always_comb begin
        src_o         = '0;
        src_o[BIT_HI]  = hi_i;
        src_o[BIT_MAV] = mav_i;
        src_o[BIT_LO]  = lo_i;
    end

    // summary over source bits only; the summary position itself is masked out
    assign mss_o = |(src_o & en_i & SRC_MASK);
endmodule

// File: rtl/srq_enable_reg.sv
module srq_enable_reg
    import srq_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i)
            en_o <= wdata_i & SRC_MASK;
    end
endmodule

// File: rtl/srq_edge_detect.sv
module srq_edge_detect
    import srq_pkg::*;
#(
    parameter int W = SB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] en_i,
    output logic         rise_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise_vec;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (SRC_MASK[b]) begin : g_src
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    prev_q[b] <= 1'b0;
                else
                    prev_q[b] <= src_i[b];
            end
            assign rise_vec[b] = src_i[b] & ~prev_q[b] & en_i[b];
        end else begin : g_none
            assign prev_q[b]   = 1'b0;
            assign rise_vec[b] = 1'b0;
        end
    end

    assign rise_o = |rise_vec;
endmodule

// File: rtl/srq_request_fsm.sv
module srq_request_fsm
    import srq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic poll_rd_i,
    output logic srq_o
);
    req_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= REQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:    if (rise_i) state_d = REQ_PENDING;               // RAISE
            REQ_PENDING: if (poll_rd_i && !rise_i) state_d = REQ_IDLE;    // POLL_CLEAR / HOLD
            default:     state_d = REQ_IDLE;
        endcase
    end

    // the request is visible in the same cycle as the edge
    always_comb begin
        srq_o = (state_q == REQ_PENDING) || rise_i;
    end
endmodule

// File: rtl/srq_status_core.sv
module srq_status_core
    import srq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_hi_i,
    input  logic       queue_nonempty_i,
    input  logic       evt_lo_i,
    input  logic       en_wr_i,
    input  logic [7:0] en_wdata_i,
    output logic [7:0] enable_q,
    output logic [7:0] status_byte,
    input  logic       poll_rd_i,
    output logic [7:0] poll_byte,
    output logic       srq_o
);
    logic [SB_W-1:0] src;
    logic            mss;
    logic            rise;

    srq_enable_reg #(.W(SB_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_i(en_wr_i), .wdata_i(en_wdata_i), .en_o(enable_q)
    );

    srq_status_assemble #(.W(SB_W)) u_asm (
        .hi_i(evt_hi_i), .mav_i(queue_nonempty_i), .lo_i(evt_lo_i),
        .en_i(enable_q), .src_o(src), .mss_o(mss)
    );

    srq_edge_detect #(.W(SB_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .src_i(src), .en_i(enable_q), .rise_o(rise)
    );

    srq_request_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .poll_rd_i(poll_rd_i), .srq_o(srq_o)
    );

    always_comb begin
        status_byte          = src;
        status_byte[BIT_MSS] = mss;
        poll_byte            = src;
        poll_byte[BIT_MSS]   = srq_o;
    end
endmodule

// File: rtl/srq_status_checker.sv
module srq_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_hi_i,
    input logic       queue_nonempty_i,
    input logic       evt_lo_i,
    input logic [7:0] enable_q,
    input logic [7:0] status_byte,
    input logic       poll_rd_i,
    input logic [7:0] poll_byte,
    input logic       srq_o
);
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte & 8'h8E) == 8'h00);

    assert_enable_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q & 8'hCE) == 8'h00);

    assert_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6] == ((evt_hi_i & enable_q[5]) | (queue_nonempty_i & enable_q[4])
                           | (evt_lo_i & enable_q[0])));

    assert_rise_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hi_i && !$past(evt_hi_i) && enable_q[5]) |-> srq_o);

    assert_rise_mav_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_nonempty_i && !$past(queue_nonempty_i) && enable_q[4]) |-> srq_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (srq_o && !poll_rd_i) |=> srq_o);

    assert_poll_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_byte[6] == srq_o);
endmodule

bind srq_status_core srq_status_checker u_chk (
    .clk(clk), .rst_n(rst_n), .evt_hi_i(evt_hi_i), .queue_nonempty_i(queue_nonempty_i),
    .evt_lo_i(evt_lo_i), .enable_q(enable_q), .status_byte(status_byte),
    .poll_rd_i(poll_rd_i), .poll_byte(poll_byte), .srq_o(srq_o)
);

// File: tb/sim_srq_status_core.sv
`timescale 1ns/1ps
module sim_srq_status_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi = 1'b0, mav = 1'b0, lo = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd = 1'b0;
    logic [7:0] enable_q, status_byte, poll_byte;
    logic       srq_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // reference model state
    int m_en = 0;
    int m_p_hi = 0, m_p_mav = 0, m_p_lo = 0;
    int m_pend = 0;

    always #10 clk = ~clk;

    srq_status_core u0 (
        .clk(clk), .rst_n(rst_n), .evt_hi_i(hi), .queue_nonempty_i(mav), .evt_lo_i(lo),
        .en_wr_i(wr), .en_wdata_i(wdata), .enable_q(enable_q), .status_byte(status_byte),
        .poll_rd_i(rd), .poll_byte(poll_byte), .srq_o(srq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // drive one cycle, compare against model, then advance model at the edge
    task automatic step(input bit h, input bit m, input bit l,
                        input bit w, input int wd, input bit r, input string req);
        int mss, rise, st, srq, pb;
        @(negedge clk);
        hi = h; mav = m; lo = l; wr = w; wdata = wd[7:0]; rd = r;
        #1;
        mss  = (h & m_en[5]) | (m & m_en[4]) | (l & m_en[0]);
        rise = (h & !m_p_hi & m_en[5]) | (m & !m_p_mav & m_en[4]) | (l & !m_p_lo & m_en[0]);
        srq  = m_pend | rise;
        st   = (mss << 6) | (h << 5) | (m << 4) | l;
        pb   = (srq << 6) | (h << 5) | (m << 4) | l;
        chk({req, " R2/R4 status"}, status_byte, st);
        chk({req, " R5/R6 srq"}, srq_o, srq);
        chk({req, " R7 poll"}, poll_byte, pb);
        chk({req, " R3 enable"}, enable_q, m_en);
        @(posedge clk);
        if (rise) m_pend = 1; else if (r) m_pend = 0;
        m_p_hi = h; m_p_mav = m; m_p_lo = l;
        if (w) m_en = wd & 8'h31;
        cyc++;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        step(0,0,0, 0,0,   0, "R1");
        step(1,1,1, 0,0,   0, "R1 no enable");
        step(0,0,0, 0,0,   0, "R1");
        // R3: write all ones, only 5,4,0 stored
        step(0,0,0, 1,'hFF,0, "R3 write");
        step(0,0,0, 0,0,   0, "R3 readback");
        step(0,0,0, 1,'h20,0, "R3 write bit5");
        // R5: rising edge on enabled bit 5
        step(1,0,0, 0,0,   0, "R5 rise hi");
        step(1,0,0, 0,0,   0, "R7 hold");
        step(1,0,0, 0,0,   1, "R7 poll");
        step(1,0,0, 0,0,   0, "R6 steady level");
        step(1,0,0, 0,0,   0, "R6 steady level");
        // R6: disabled bits rise
        step(1,1,1, 0,0,   0, "R6 disabled rise");
        step(0,0,0, 0,0,   0, "R6 fall");
        // R8: rise coincides with poll
        step(1,0,0, 0,0,   0, "R8 raise");
        step(0,0,0, 0,0,   0, "R8 drop");
        step(1,0,0, 0,0,   1, "R8 rise+poll");
        step(1,0,0, 0,0,   0, "R8 still pending");
        step(1,0,0, 0,0,   1, "R7 clear");
        step(1,0,0, 0,0,   0, "R7 cleared");
        // enable write coinciding with rise of bit 4: not yet enabled
        step(1,1,0, 1,'h11,0, "R3 write same cycle");
        step(1,1,0, 0,0,   0, "R3 effective next");
        step(1,0,1, 0,0,   0, "R5 rise lo");
        step(1,0,1, 0,0,   1, "R7 poll");
        step(1,1,1, 0,0,   0, "R5 rise mav");
        step(1,1,1, 0,0,   1, "R7 poll");
        step(1,1,1, 0,0,   0, "R4 summary level");
        step(0,0,0, 1,'h40,0, "R3 bit6 write");
        step(1,1,1, 0,0,   0, "R3 bit6 ignored");
        step(1,1,1, 0,0,   0, "R4 no mask");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule